// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits in front of a byte-wide nonvolatile memory's page write engine. It watches every write cycle on the host bus and passes judgement on each one. Two keyed command sequences are recognised from address and data together. A three-write unlock sequence arms protection and opens a one-shot window for a single page load. A six-write disable sequence returns the memory to unprotected operation. Command writes are absorbed and never reach the array. Every other write is forwarded only when protection is off, or when an unlock window is open and not yet full.

The protection flag is nonvolatile in intent. A soft reset does not clear it. Only a separate factory-clear reset returns it to the unprotected default. A soft reset does abort any partly matched sequence and closes an open window. The page write engine reports when the page it loaded has finished programming. At that point the window closes and writes are blocked again.

Top module: `swp_sequencer`

## Requirements
- R1: After the factory-clear reset `fclr_ni`, `prot_en_o` is 0. A soft reset on `rst_ni` alone leaves `prot_en_o` unchanged.
- R2: While `prot_en_o` is 0, every write that is not a command step is forwarded: `wr_permit_o`=1 and `cmd_taken_o`=0 in the cycle `wr_valid_i` is high.
- R3: A write that matches the next expected command step gives `cmd_taken_o`=1 and `wr_permit_o`=0 in the same cycle.
- R4: The steps (data@address, hex) 0xAA@0x1555, 0x55@0x0AAA and 0xA0@0x1555 form the unlock sequence. After its third write, `prot_en_o` is 1 in the next cycle, whatever its earlier value, and a page-load window opens.
- R5: While the window is open, the first PAGE_BYTES writes are forwarded whatever their address and data. Further writes in that window are blocked. No command decoding takes place inside the window.
- R6: A pulse on `page_done_i` while the window is open closes it from the next cycle on.
- R7: The steps 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA and 0x20@0x1555 form the disable sequence. After its sixth write, `prot_en_o` is 0 in the next cycle.
- R8: A write that does not match the next expected step returns the decoder to its idle state. That write is then treated as an ordinary write: forwarded if protection is off, blocked if it is on.
- R9: While `prot_en_o` is 1 and no window is open, ordinary writes are blocked: `wr_permit_o`=0 and `cmd_taken_o`=0.
- R10: A soft reset returns the decoder to idle and closes any open window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Soft reset, asynchronous, active low |
| fclr_ni | input | 1 | Factory clear of protection state, asynchronous, active low |
| wr_valid_i | input | 1 | A write cycle is presented this clock |
| wr_addr_i | input | 13 | Write address |
| wr_data_i | input | 8 | Write data |
| page_done_i | input | 1 | Page engine finished programming the loaded page |
| wr_permit_o | output | 1 | Forward this write to the page write engine |
| prot_en_o | output | 1 | Software protection is armed |
| cmd_taken_o | output | 1 | This write was absorbed as a command step |

## Verification
A decoder stuck at a wrong step shows up at the very next command write. A correct step is then not absorbed, or a stray write is wrongly taken, visible on `cmd_taken_o` in that same cycle. A byte counter or window flag that is off by one appears on `wr_permit_o` at the boundary write just after PAGE_BYTES, or at the first write after `page_done_i`. A corrupted protection flag is seen on `prot_en_o` one cycle after the final step of either sequence. It also shows on the permit of the next ordinary write.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam int unsigned ADDR_W = 13;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] KEY_ADDR_A = 13'h1555;
  localparam logic [ADDR_W-1:0] KEY_ADDR_B = 13'h0AAA;
  localparam logic [DATA_W-1:0] KEY_D1     = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_D2     = 8'h55;
  localparam logic [DATA_W-1:0] KEY_LOCK   = 8'hA0;
  localparam logic [DATA_W-1:0] KEY_ERASE  = 8'h80;
  localparam logic [DATA_W-1:0] KEY_OFF    = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_D3, ST_D4, ST_D5
  } step_e;

  function automatic logic key_hit(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                                   logic [ADDR_W-1:0] ka, logic [DATA_W-1:0] kd);
    return (a == ka) && (d == kd);
  endfunction
endpackage

// File: rtl/swp_matcher.sv
module swp_matcher
  import swp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o,
  output logic              lock_o,
  output logic              off_o
);
  step_e step_q, step_d;

  always_comb begin
    step_d = step_q;
    hit_o  = 1'b0;
    lock_o = 1'b0;
    off_o  = 1'b0;
    if (wr_i && en_i) begin
      step_d = ST_IDLE;
      unique case (step_q)
        ST_IDLE: if (key_hit(addr_i, data_i, KEY_ADDR_A, KEY_D1)) begin hit_o = 1'b1; step_d = ST_K1; end
        ST_K1:   if (key_hit(addr_i, data_i, KEY_ADDR_B, KEY_D2)) begin hit_o = 1'b1; step_d = ST_K2; end
        ST_K2: begin
          if (key_hit(addr_i, data_i, KEY_ADDR_A, KEY_LOCK)) begin
            hit_o = 1'b1; lock_o = 1'b1;
          end else if (key_hit(addr_i, data_i, KEY_ADDR_A, KEY_ERASE)) begin
            hit_o = 1'b1; step_d = ST_D3;
          end
        end
        ST_D3:   if (key_hit(addr_i, data_i, KEY_ADDR_A, KEY_D1)) begin hit_o = 1'b1; step_d = ST_D4; end
        ST_D4:   if (key_hit(addr_i, data_i, KEY_ADDR_B, KEY_D2)) begin hit_o = 1'b1; step_d = ST_D5; end
        ST_D5:   if (key_hit(addr_i, data_i, KEY_ADDR_A, KEY_OFF)) begin hit_o = 1'b1; off_o = 1'b1; end
        default: step_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) step_q <= ST_IDLE;
    else         step_q <= step_d;

  // a miss always returns to idle
  assert_miss_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && en_i && !hit_o) |=> (step_q == ST_IDLE));
  assert_final_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o || off_o) |=> (step_q == ST_IDLE));
endmodule

// File: rtl/swp_window.sv
module swp_window #(
  parameter int unsigned PAGE_BYTES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic open_i,
  input  logic close_i,
  input  logic wr_i,
  output logic open_o,
  output logic full_o
);
  localparam int unsigned CW = $clog2(PAGE_BYTES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PAGE_BYTES);

  logic          open_q;
  logic [CW-1:0] cnt_q;

  assign open_o = open_q;
  assign full_o = (cnt_q == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (open_i) begin
      open_q <= 1'b1;
      cnt_q  <= '0;
    end else if (open_q && close_i) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (open_q && wr_i && !full_o) begin
      cnt_q  <= cnt_q + 1'b1;
    end

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  assert_close_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_q && close_i && !open_i) |=> !open_q);
endmodule

// File: rtl/swp_sequencer.sv
module swp_sequencer
  import swp_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fclr_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              page_done_i,
  output logic              wr_permit_o,
  output logic              prot_en_o,
  output logic              cmd_taken_o
);
  logic hit, lock_fire, off_fire, win_open, win_full, prot_q;

  swp_matcher i_matcher (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (!win_open),
    .wr_i   (wr_valid_i),
    .addr_i (wr_addr_i),
    .data_i (wr_data_i),
    .hit_o  (hit),
    .lock_o (lock_fire),
    .off_o  (off_fire)
  );

  swp_window #(.PAGE_BYTES(PAGE_BYTES)) i_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .open_i  (lock_fire),
    .close_i (page_done_i),
    .wr_i    (wr_valid_i),
    .open_o  (win_open),
    .full_o  (win_full)
  );

  // protection state survives soft reset; only factory clear resets it
  always_ff @(posedge clk_i or negedge fclr_ni)
    if (!fclr_ni)       prot_q <= 1'b0;
    else if (lock_fire) prot_q <= 1'b1;
    else if (off_fire)  prot_q <= 1'b0;

  assign prot_en_o   = prot_q;
  assign cmd_taken_o = wr_valid_i && !win_open && hit;
  assign wr_permit_o = wr_valid_i && (win_open ? !win_full : (!hit && !prot_q));

  assert_cmd_blocked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !fclr_ni)
    !(cmd_taken_o && wr_permit_o));
  assert_lock_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !fclr_ni)
    lock_fire |=> (prot_en_o && win_open));
  assert_off_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || !fclr_ni)
    off_fire |=> !prot_en_o);
  assert_prot_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni || !fclr_ni)
    !cmd_taken_o |=> $stable(prot_en_o));
  assert_locked_block_R9: assert property (@(posedge clk_i) disable iff (!rst_ni || !fclr_ni)
    (prot_en_o && !win_open && !cmd_taken_o) |-> !wr_permit_o);
endmodule

// File: tb/test_swp_sequencer.sv
`timescale 1ns/1ps
module test_swp_sequencer;
  localparam int PB = 8;

  logic clk = 1'b0, rst_n = 1'b0, fclr_n = 1'b0;
  logic wv = 1'b0, pd = 1'b0;
  logic [12:0] wa = '0;
  logic [7:0]  wd = '0;
  logic permit, prot, taken;
  int nvec = 0, nbad = 0;

  always #2 clk = ~clk;

  swp_sequencer #(.PAGE_BYTES(PB)) i_swp_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .fclr_ni(fclr_n),
    .wr_valid_i(wv), .wr_addr_i(wa), .wr_data_i(wd), .page_done_i(pd),
    .wr_permit_o(permit), .prot_en_o(prot), .cmd_taken_o(taken));

  task automatic chk(string req, logic act, logic exp, string what);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [7:0] d, logic ep, logic et, string req);
    @(negedge clk); wv = 1'b1; wa = a; wd = d;
    #1 chk(req, permit, ep, "permit"); chk(req, taken, et, "taken");
    @(posedge clk); #0.5 wv = 1'b0;
  endtask

  task automatic prot_is(logic e, string req);
    @(negedge clk); chk(req, prot, e, "prot");
  endtask

  task automatic done_pulse();
    @(negedge clk); pd = 1'b1; @(negedge clk); pd = 1'b0;
  endtask

  task automatic soft_rst();
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic unlock(string req);
    wr(13'h1555, 8'hAA, 1'b0, 1'b1, req);
    wr(13'h0AAA, 8'h55, 1'b0, 1'b1, req);
    wr(13'h1555, 8'hA0, 1'b0, 1'b1, req);
  endtask

  task automatic disable_seq(string req);
    wr(13'h1555, 8'hAA, 1'b0, 1'b1, req);
    wr(13'h0AAA, 8'h55, 1'b0, 1'b1, req);
    wr(13'h1555, 8'h80, 1'b0, 1'b1, req);
    wr(13'h1555, 8'hAA, 1'b0, 1'b1, req);
    wr(13'h0AAA, 8'h55, 1'b0, 1'b1, req);
    wr(13'h1555, 8'h20, 1'b0, 1'b1, req);
  endtask

  // abort after k correct disable-path steps; miss write is ordinary
  task automatic abort_sweep(logic p);
    logic [12:0] sa [6] = '{13'h1555, 13'h0AAA, 13'h1555, 13'h1555, 13'h0AAA, 13'h1555};
    logic [7:0]  sd [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < k; j++) wr(sa[j], sd[j], 1'b0, 1'b1, "R3");
      wr(13'h0000, 8'h00, !p, 1'b0, "R8");
      wr(13'h0AAA, 8'h55, !p, 1'b0, "R8");  // decoder must be idle
      prot_is(p, "R8");
    end
  endtask

  initial begin
    #(200000 * 4);
    nbad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1; fclr_n = 1'b1;
    prot_is(1'b0, "R1");
    chk("R1", permit, 1'b0, "idle permit");
    chk("R1", taken, 1'b0, "idle taken");

    for (int i = 0; i < 16; i++)
      wr(13'(i * 517), 8'(i * 37 + 1), 1'b1, 1'b0, "R2");

    unlock("R3");
    prot_is(1'b1, "R4");
    for (int i = 0; i < PB; i++) wr(13'h1555, 8'hAA, 1'b1, 1'b0, "R5");
    wr(13'h0040, 8'h11, 1'b0, 1'b0, "R5");
    done_pulse();
    wr(13'h0041, 8'h22, 1'b0, 1'b0, "R6");
    wr(13'h1000, 8'h33, 1'b0, 1'b0, "R9");

    for (int n = 1; n <= PB; n++) begin
      unlock("R4");
      for (int i = 0; i < n; i++) wr(13'(n * 64 + i), 8'(i), 1'b1, 1'b0, "R5");
      done_pulse();
      wr(13'(n * 64), 8'hFF, 1'b0, 1'b0, "R6");
    end

    wr(13'h1555, 8'hAA, 1'b0, 1'b1, "R3");
    wr(13'h0AAA, 8'h55, 1'b0, 1'b1, "R3");
    soft_rst();
    wr(13'h1555, 8'hA0, 1'b0, 1'b0, "R10");
    prot_is(1'b1, "R1");
    unlock("R4");
    wr(13'h0100, 8'h01, 1'b1, 1'b0, "R5");
    soft_rst();
    wr(13'h0101, 8'h02, 1'b0, 1'b0, "R10");

    abort_sweep(1'b1);

    disable_seq("R3");
    prot_is(1'b0, "R7");
    wr(13'h0200, 8'h5A, 1'b1, 1'b0, "R7");

    abort_sweep(1'b0);

    unlock("R4");
    prot_is(1'b1, "R4");
    done_pulse();
    @(negedge clk); fclr_n = 1'b0; @(negedge clk); fclr_n = 1'b1;
    prot_is(1'b0, "R1");
    wr(13'h0300, 8'hC3, 1'b1, 1'b0, "R2");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule